// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

The block watches the demodulated output of an infrared receiver and measures how long each mark (active level) and each space (idle level) lasts. Lengths are counted in ticks of a programmable sample clock. Each length is stored as one saturating 8-bit value in a fixed bank of entries. Four entries are packed into every 32-bit capture word. The raw input is first synchronised, then passes through a de-glitch filter, and only then reaches the capture engine.

Capture begins at the first accepted mark. It ends when a space lasts longer than a programmable timeout. The block then flags a pending interrupt and freezes the bank, so software can read the whole message without racing new edges. A restart command zeroes the bank and re-arms the engine. Software controls the block through a plain word-addressed register port with combinational read data.

Register map (word addresses): 0 configuration, 1 threshold, 2 sample period, 3 restart, 4 interrupt enable, 5 interrupt clear, 16 to 16+NUM_WORDS-1 capture words. The input is active-low with the default ACTIVE_LOW=1, so ir_i=0 is a mark.

Top module: `irw_rx`

## Requirements
- R1: After reset irq_o is 0. Every capture word reads 0. The configuration, threshold and period registers read 0.
- R2: Entries are stored in order starting with a mark and then alternating mark, space. Each entry holds the segment length in sample ticks. Entry k sits in capture word 16+k/4 at bits 8*(k%4)+7 : 8*(k%4).
- R3: A segment longer than 255 ticks is stored as 0xFF. It is not wrapped.
- R4: The bank holds 4*NUM_WORDS entries (68 by default). Once the bank is full, later edges are discarded and no stored entry changes.
- R5: The message ends when a space lasts more than ok*OK_UNIT ticks, where ok is configuration bits 22:16 (a value of 0 acts as 1). The entry for that space and every later entry stay 0, and the interrupt becomes pending. A shorter space does not end the message.
- R6: After the message ends, further input edges do not change any capture word until a restart.
- R7: Writing 1 to bit 0 of address 3 zeroes every capture word and re-arms capture for the next mark.
- R8: irq_o is high when an interrupt is pending and bit 0 of address 4 is 1. Writing 1 to bit 0 of address 5 clears the pending flag.
- R9: A level change is accepted only after max(dg,1) consecutive ticks at the new level, where dg is threshold bits 12:8. Shorter glitches are ignored.
- R10: A tick occurs every period+1 clocks, where period is held at address 2 in bits PERIOD_W-1:0. Widths count ticks.
- R11: Capture advances only when configuration bit 0 (enable) and bit 13 (width-detection enable) are both 1.
- R12: Configuration reads back bits 0, 13 and 22:16; threshold reads back bits 12:8; period reads back bits PERIOD_W-1:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared input, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt, level |

## Verification
The bench builds the block with OK_UNIT=16 and keeps NUM_WORDS=17 and PERIOD_W=16. The small timeout unit lets the end-of-message space stay within a few hundred ticks. It also lets the timeout be set above 255 ticks, so saturated spaces can be checked without ending the message. Running a period of 0 makes a tick on every clock, so widths equal clock counts. One test uses period 3 to cover the divider. Filling all 68 entries with a mix of widths covers the full-bank stop.

// File: rtl/irw_pkg.sv
package irw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FULL, ST_DONE} cap_state_e;
  localparam int A_CFG     = 0;
  localparam int A_THD     = 1;
  localparam int A_PERIOD  = 2;
  localparam int A_RESTART = 3;
  localparam int A_IRQ_EN  = 4;
  localparam int A_IRQ_CLR = 5;
  localparam int A_CAP     = 16;
  localparam int DG_W      = 5;
  localparam int OK_W      = 7;
endpackage

// File: rtl/irw_tick.sv
module irw_tick #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irw_filter.sv
module irw_filter #(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int DG_W       = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ir_i,
  input  logic            tick_i,
  input  logic [DG_W-1:0] dg_i,
  output logic            mark_o,
  output logic            chg_o
);
  localparam logic IDLE_RAW = ACTIVE_LOW ? 1'b1 : 1'b0;

  logic            s1_q, s2_q, raw_mark;
  logic            mark_q;
  logic [DG_W-1:0] run_q;
  logic [DG_W:0]   need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= IDLE_RAW;
      s2_q <= IDLE_RAW;
    end else begin
      s1_q <= ir_i;
      s2_q <= s1_q;
    end
  end

  generate
    if (ACTIVE_LOW) begin : g_low
      assign raw_mark = ~s2_q;
    end else begin : g_high
      assign raw_mark = s2_q;
    end
  endgenerate

  assign need   = (dg_i == '0) ? (DG_W+1)'(1) : {1'b0, dg_i};
  assign chg_o  = tick_i && (raw_mark != mark_q) && (({1'b0, run_q} + 1'b1) >= need);
  assign mark_o = mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_q <= 1'b0;
      run_q  <= '0;
    end else if (tick_i) begin
      if (raw_mark == mark_q) run_q <= '0;
      else if (chg_o) begin
        mark_q <= raw_mark;
        run_q  <= '0;
      end else run_q <= run_q + 1'b1;
    end
  end

  // accepted level only moves on a sample tick
  p_change_on_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mark_q) |-> $past(tick_i));
endmodule

// File: rtl/irw_engine.sv
module irw_engine
  import irw_pkg::*;
#(
  parameter int NUM_ENT = 68,
  parameter int OK_UNIT = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    active_i,
  input  logic                    mark_i,
  input  logic                    chg_i,
  input  logic                    restart_i,
  input  logic [OK_W-1:0]         ok_i,
  output logic [NUM_ENT-1:0][7:0] ent_o,
  output logic                    done_set_o
);
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int SEG_W = OK_W + $clog2(OK_UNIT) + 1;

  cap_state_e              st_q;
  logic [IDX_W-1:0]        idx_q;
  logic [SEG_W-1:0]        seg_q, seg_inc, limit;
  logic [NUM_ENT-1:0][7:0] ent_q;
  logic [7:0]              width8;
  logic [OK_W-1:0]         ok_eff;
  logic                    step, end_hit;

  assign ok_eff  = (ok_i == '0) ? OK_W'(1) : ok_i;
  assign limit   = SEG_W'(ok_eff) * SEG_W'(OK_UNIT);
  assign seg_inc = (&seg_q) ? seg_q : seg_q + 1'b1;
  assign width8  = (seg_q > SEG_W'(255)) ? 8'hFF : seg_q[7:0];
  assign step    = tick_i && active_i && !restart_i;
  assign end_hit = step && (st_q == ST_RUN || st_q == ST_FULL) && !chg_i &&
                   !mark_i && (seg_q == limit);
  assign done_set_o = end_hit;
  assign ent_o      = ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      seg_q <= '0;
      ent_q <= '0;
    end else if (restart_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      seg_q <= '0;
      ent_q <= '0;
    end else if (step) begin
      case (st_q)
        ST_IDLE: if (chg_i && !mark_i) begin
          st_q  <= ST_RUN;
          idx_q <= '0;
          seg_q <= SEG_W'(1);
        end
        ST_RUN: begin
          if (chg_i) begin
            ent_q[idx_q] <= width8;
            seg_q        <= SEG_W'(1);
            if (idx_q == IDX_W'(NUM_ENT-1)) st_q <= ST_FULL;
            else idx_q <= idx_q + 1'b1;
          end else begin
            seg_q <= seg_inc;
            if (end_hit) st_q <= ST_DONE;
          end
        end
        ST_FULL: begin
          if (chg_i) seg_q <= SEG_W'(1);
          else begin
            seg_q <= seg_inc;
            if (end_hit) st_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  p_idx_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(NUM_ENT-1));
  p_full_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FULL && !restart_i) |=> $stable(ent_q));
  p_done_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !restart_i) |=> $stable(ent_q));
  p_restart_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (ent_q == '0 && st_q == ST_IDLE));
endmodule

// File: rtl/irw_rx.sv
module irw_rx
  import irw_pkg::*;
#(
  parameter int NUM_WORDS  = 17,
  parameter int PERIOD_W   = 16,
  parameter int OK_UNIT    = 128,
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int ADDR_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int NUM_ENT = 4 * NUM_WORDS;
  localparam int WIDX_W  = $clog2(NUM_WORDS);

  logic                    en_q, pw_q, irq_en_q, pend_q;
  logic [OK_W-1:0]         ok_q;
  logic [DG_W-1:0]         dg_q;
  logic [PERIOD_W-1:0]     period_q;
  logic                    tick, mark, chg, restart, irq_clr, done_set;
  logic [NUM_ENT-1:0][7:0] ent;
  logic [NUM_WORDS-1:0][31:0] words;
  logic [ADDR_W-1:0]       widx;
  logic                    wr_unused;

  assign wr_unused = ^{wdata_i[31:23], wdata_i[15:14], wdata_i[12:1]};
  assign restart = wr_en_i && addr_i == ADDR_W'(A_RESTART) && wdata_i[0];
  assign irq_clr = wr_en_i && addr_i == ADDR_W'(A_IRQ_CLR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; pw_q <= 1'b0; ok_q <= '0; dg_q <= '0;
      period_q <= '0; irq_en_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        if (addr_i == ADDR_W'(A_CFG)) begin
          en_q <= wdata_i[0];
          pw_q <= wdata_i[13];
          ok_q <= wdata_i[22:16];
        end
        if (addr_i == ADDR_W'(A_THD))    dg_q     <= wdata_i[12:8];
        if (addr_i == ADDR_W'(A_PERIOD)) period_q <= wdata_i[PERIOD_W-1:0];
        if (addr_i == ADDR_W'(A_IRQ_EN)) irq_en_q <= wdata_i[0];
      end
      if (done_set)     pend_q <= 1'b1;
      else if (irq_clr) pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q & irq_en_q;

  irw_tick #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk_i, .rst_ni, .period_i(period_q), .tick_o(tick)
  );

  irw_filter #(.ACTIVE_LOW(ACTIVE_LOW), .DG_W(DG_W)) u_filter (
    .clk_i, .rst_ni, .ir_i, .tick_i(tick), .dg_i(dg_q), .mark_o(mark), .chg_o(chg)
  );

  irw_engine #(.NUM_ENT(NUM_ENT), .OK_UNIT(OK_UNIT)) u_engine (
    .clk_i, .rst_ni, .tick_i(tick), .active_i(en_q & pw_q), .mark_i(mark),
    .chg_i(chg), .restart_i(restart), .ok_i(ok_q), .ent_o(ent), .done_set_o(done_set)
  );

  assign words = ent;
  assign widx  = addr_i - ADDR_W'(A_CAP);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CFG))         rdata_o = {9'b0, ok_q, 2'b0, pw_q, 12'b0, en_q};
    else if (addr_i == ADDR_W'(A_THD))    rdata_o = {19'b0, dg_q, 8'b0};
    else if (addr_i == ADDR_W'(A_PERIOD)) rdata_o = 32'(period_q);
    else if (addr_i == ADDR_W'(A_IRQ_EN)) rdata_o = {31'b0, irq_en_q};
    else if (addr_i >= ADDR_W'(A_CAP) && widx < ADDR_W'(NUM_WORDS))
      rdata_o = words[widx[WIDX_W-1:0]];
  end

  p_irq_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr && !done_set) |=> !irq_o);
  p_irq_needs_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(done_set));
endmodule

// File: tb/irw_rx_bench.sv
module irw_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0, per = 0;
  logic [7:0] full_exp [68];

  irw_rx #(.NUM_WORDS(17), .PERIOD_W(16), .OK_UNIT(16)) u_irw_rx (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 6'(a);
    #1 d = rdata;
  endtask

  task automatic seg(input bit is_mark, input int ticks);
    ir = is_mark ? 1'b0 : 1'b1;
    repeat (ticks * (per + 1)) @(negedge clk);
  endtask

  task automatic setup(input int ok, input int dg, input int p, input bit pw);
    per = p;
    wr(0, 32'(ok) << 16 | (pw ? 32'h2000 : 32'h0) | 32'h1);
    wr(1, 32'(dg) << 8);
    wr(2, 32'(p));
    wr(4, 32'h1);
    wr(3, 32'h1);
    wr(5, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(0, d);  chk("R1 cfg", d, 32'h0);
    rd(1, d);  chk("R1 thd", d, 32'h0);
    rd(2, d);  chk("R1 period", d, 32'h0);
    rd(16, d); chk("R1 word0", d, 32'h0);
    rd(32, d); chk("R1 word16", d, 32'h0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R12 cfg", d, 32'h007F_2001);
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R12 thd", d, 32'h0000_1F00);
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R12 period", d, 32'h0000_FFFF);
    wr(0, 32'h0); wr(1, 32'h0); wr(2, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    setup(4, 0, 0, 1'b1);
    seg(1, 10); seg(0, 20); seg(1, 30); seg(0, 40); seg(1, 50);
    seg(0, 30);
    chk("R5 short space no end", {31'b0, irq}, 32'h0);
    seg(0, 170);
    rd(16, d); chk("R2 word0", d, 32'h281E_140A);
    rd(17, d); chk("R5 word1 end zero", d, 32'h0000_0032);
    rd(18, d); chk("R5 word2", d, 32'h0);
    chk("R5 irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(4, 32'h0); chk("R8 masked", {31'b0, irq}, 32'h0);
    wr(4, 32'h1); chk("R8 unmasked", {31'b0, irq}, 32'h1);
    rd(4, d);     chk("R8 en readback", d, 32'h1);
    wr(5, 32'h1); chk("R8 cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sat;
    logic [31:0] d;
    setup(20, 0, 0, 1'b1);
    seg(1, 300); seg(0, 280); seg(1, 5); seg(0, 400);
    rd(16, d); chk("R3 saturate", d, 32'h0005_FFFF);
    chk("R3 irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_full;
    logic [31:0] d;
    setup(4, 0, 0, 1'b1);
    for (int k = 0; k < 68; k++)
      full_exp[k] = (k % 2 == 0) ? 8'((k/2) % 7 + 2) : 8'((k/2) % 5 + 2);
    for (int p = 0; p < 40; p++) begin
      seg(1, p % 7 + 2);
      seg(0, p % 5 + 2);
    end
    seg(0, 200);
    for (int w = 0; w < 17; w++) begin
      rd(16 + w, d);
      chk($sformatf("R4 full word%0d", w), d,
          {full_exp[4*w+3], full_exp[4*w+2], full_exp[4*w+1], full_exp[4*w]});
    end
    chk("R4 irq after full", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    seg(1, 10); seg(0, 10); seg(1, 10); seg(0, 100);
    rd(16, d);
    chk("R6 frozen word0", d, {full_exp[3], full_exp[2], full_exp[1], full_exp[0]});
    rd(32, d);
    chk("R6 frozen word16", d, {full_exp[67], full_exp[66], full_exp[65], full_exp[64]});
  endtask

  task automatic t_restart;
    logic [31:0] d;
    logic [31:0] acc;
    wr(3, 32'h1);
    acc = '0;
    for (int w = 0; w < 17; w++) begin
      rd(16 + w, d);
      acc = acc | d;
    end
    chk("R7 bank zero", acc, 32'h0);
    seg(1, 7); seg(0, 9); seg(1, 11); seg(0, 100);
    rd(16, d); chk("R7 rearmed", d, 32'h000B_0907);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    setup(4, 3, 0, 1'b1);
    seg(1, 2); seg(0, 50);
    rd(16, d); chk("R9 glitch ignored", d, 32'h0);
    seg(1, 10); seg(0, 12); seg(1, 14); seg(0, 100);
    rd(16, d); chk("R9 filtered widths", d, 32'h000E_0C0A);
  endtask

  task automatic t_period;
    logic [31:0] d;
    setup(4, 0, 3, 1'b1);
    seg(1, 10); seg(0, 12); seg(1, 5); seg(0, 100);
    rd(16, d); chk("R10 divided widths", d, 32'h0005_0C0A);
    chk("R10 irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    setup(4, 0, 0, 1'b0);
    seg(1, 10); seg(0, 10); seg(1, 10); seg(0, 100);
    rd(16, d); chk("R11 no capture when disabled", d, 32'h0);
    chk("R11 no irq when disabled", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_basic;
    t_irq;
    t_sat;
    t_full;
    t_freeze;
    t_restart;
    t_glitch;
    t_period;
    t_enable;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule